// File: doc/BRIEF.md
# Chained Rail Enable Sequencer

The block drives the enable lines of four power rails from a single enable input, so that the rails come up in a fixed chain. The enable only counts once the power-on-reset-done input is high. Rail 0 rises a programmed number of cycles after the qualified enable goes high. Each later rail rises its own programmed delay after the rail before it is up. A per-rail pair of delay fields sets the up and down timing in clock cycles.

When the qualified enable is removed, a mode input selects one of two behaviours. In instant mode every rail drops on the same clock edge. In staged mode the rails shut down in reverse order, each after its own down delay. Raising the enable again during a staged shutdown stops it, and power-up continues from the lowest rail that is still off.

A power-good mode makes each stage after rail 0 wait for a good flag from the converter of the rail before it. The good flags pass through a two-flop synchronizer before use.

Each rail is controlled by one stage FSM with four states. OFF goes to RAMP when the stage's trigger (qualified enable together with its go-up condition) is true; this loads the up counter. RAMP goes back to OFF if the trigger drops (abort), or on to ON when the counter reaches zero. ON goes to OFF in instant mode once the enable is lost (drop). ON goes to DRAIN in staged mode once the enable is lost and the next rail is off; this loads the down counter. DRAIN goes back to ON on re-enable (resume) or if the next rail is on. It goes to OFF on expiry, or at once if instant mode is selected.

Top module: `rail_sequencer`

## Requirements
- R1: While reset is asserted, and after it is released, all rail enables are low until sequencing starts.
- R2: While por_done is low the enable input has no effect: no rail rises.
- R3: Rail 0 goes high after the edge at which the qualified enable (enable AND por_done) has been sampled high on up_dly_cfg[7:0]+2 consecutive rising edges.
- R4: Rail i (i>0) goes high after rail i-1 has been sampled high on up_dly_cfg[8i+7:8i]+2 consecutive edges. Rise times therefore accumulate along the chain.
- R5: With seq_down=0, the edge that samples the qualified enable low clears every rail enable at once.
- R6: With seq_down=1 and the qualified enable low, rail 3 turns off first. Rail i turns off once rail i+1 has been sampled low on dn_dly_cfg[8i+7:8i]+2 consecutive edges. Only one rail falls per edge.
- R7: When the enable returns during a staged shutdown, rails that are still on stay on without a glitch. Power-up resumes from the lowest rail that is off.
- R8: With pg_mode=1, rail i (i>0) rises only if pg_good[i-1] is high after two synchronizer flops. That flag must stay high for the whole up delay.
- R9: If a power-good flag drops while a later rail is still ramping, that rail and all rails after it stay off. Rails already on are not affected.
- R10: If a stage's trigger drops during its up delay, the delay restarts from its full value.
- R11: A rail is never on while the rail below it is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_done | input | 1 | Power-on reset complete; qualifies enable |
| enable | input | 1 | Sequencer enable |
| seq_down | input | 1 | 1 = staged reverse shutdown, 0 = instant off |
| pg_mode | input | 1 | 1 = stages wait for power-good of the previous rail |
| pg_good | input | 3 | Power-good flags of rails 0..2 (asynchronous) |
| up_dly_cfg | input | 32 | Up delays, 8 bits per rail, rail i at bits [8i+7:8i] |
| dn_dly_cfg | input | 32 | Down delays, 8 bits per rail, same layout |
| rail_en | output | 4 | Rail enable outputs, bit i = rail i |

## Verification
Each stage's output is a decode of its state register. A change at a stage's inputs therefore shows up after the clock edge that samples it. An instant-off is due one edge after the enable drops. A rail rise or staged fall is due D+2 edges after its trigger first holds, and a power-good change needs two further edges through the synchronizer. The bench drives inputs on the falling edge. A reference model steps on every rising edge from those inputs and its own previous rail states. The outputs are compared at the next falling edge. Directed scenarios add explicit checks at the exact edge counts computed from the delay sums, and one edge earlier.

// File: rtl/seq_pkg.sv
package seq_pkg;

    // Per-rail stage states
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RAMP  = 2'd1,
        ST_ON    = 2'd2,
        ST_DRAIN = 2'd3
    } stage_t;

    localparam int SYNC_STAGES = 2;

endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            hold_q <= '0;
        end else begin
            meta_q <= d_async;
            hold_q <= meta_q;
        end
    end

    always_comb q_sync = hold_q;

endmodule

// File: rtl/rail_stage.sv
module rail_stage
    import seq_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_q,
    input  logic             go_up,
    input  logic             next_off,
    input  logic             dn_mode,
    input  logic [DLY_W-1:0] up_dly,
    input  logic [DLY_W-1:0] dn_dly,
    output logic             rail_on
);

    stage_t           state, state_nx;
    logic [DLY_W-1:0] cnt, cnt_nx;
    logic             trig_up;

    always_comb trig_up = en_q & go_up;

    // State and counter register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_OFF: begin
                if (trig_up) begin
                    state_nx = ST_RAMP;
                    cnt_nx   = up_dly;
                end
            end
            ST_RAMP: begin
                if (!trig_up) begin
                    state_nx = ST_OFF;
                end else if (cnt == '0) begin
                    state_nx = ST_ON;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
            ST_ON: begin
                if (!en_q) begin
                    if (!dn_mode) begin
                        state_nx = ST_OFF;
                    end else if (next_off) begin
                        state_nx = ST_DRAIN;
                        cnt_nx   = dn_dly;
                    end
                end
            end
            ST_DRAIN: begin
                if (en_q) begin
                    state_nx = ST_ON;
                end else if (!dn_mode) begin
                    state_nx = ST_OFF;
                end else if (!next_off) begin
                    state_nx = ST_ON;
                end else if (cnt == '0) begin
                    state_nx = ST_OFF;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
        endcase
    end

    // Output decode
    always_comb begin
        rail_on = (state == ST_ON) || (state == ST_DRAIN);
    end

endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
    import seq_pkg::*;
#(
    parameter int N_RAILS = 4,
    parameter int DLY_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       por_done,
    input  logic                       enable,
    input  logic                       seq_down,
    input  logic                       pg_mode,
    input  logic [N_RAILS-2:0]         pg_good,
    input  logic [N_RAILS*DLY_W-1:0]   up_dly_cfg,
    input  logic [N_RAILS*DLY_W-1:0]   dn_dly_cfg,
    output logic [N_RAILS-1:0]         rail_en
);

    localparam int PG_W = N_RAILS - 1;

    logic               en_q;
    logic [PG_W-1:0]    pg_ok;
    logic [N_RAILS-1:0] stage_on;
    logic [N_RAILS-1:0] go_up;
    logic [N_RAILS-1:0] next_off;

    always_comb en_q = enable & por_done;

    pg_sync #(.WIDTH(PG_W)) u_pgsync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pg_good),
        .q_sync  (pg_ok)
    );

    for (genvar g = 0; g < N_RAILS; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign go_up[g] = en_q;
        end else begin : g_chain
            assign go_up[g] = stage_on[g-1] & (~pg_mode | pg_ok[g-1]);
        end

        if (g == N_RAILS - 1) begin : g_last
            assign next_off[g] = 1'b1;
        end else begin : g_mid
            assign next_off[g] = ~stage_on[g+1];
        end

        rail_stage #(.DLY_W(DLY_W)) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_q     (en_q),
            .go_up    (go_up[g]),
            .next_off (next_off[g]),
            .dn_mode  (seq_down),
            .up_dly   (up_dly_cfg[g*DLY_W +: DLY_W]),
            .dn_dly   (dn_dly_cfg[g*DLY_W +: DLY_W]),
            .rail_on  (stage_on[g])
        );
    end

    always_comb rail_en = stage_on;

endmodule

// File: rtl/seq_chk.sv
module seq_chk #(
    parameter int N_RAILS = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               enable,
    input logic               por_done,
    input logic               seq_down,
    input logic               pg_mode,
    input logic [N_RAILS-2:0] pg_ok,
    input logic [N_RAILS-1:0] rail_en
);

    // R11
    rail_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rail_en >> 1) & ~rail_en) == '0);

    // R5
    instant_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_down && !(enable && por_done)) |=> (rail_en == '0));

    // R2
    no_rise_unqual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(enable && por_done) |=> ((rail_en & ~$past(rail_en)) == '0));

    // R6
    single_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_down && !(enable && por_done)) |=> ($countones($past(rail_en) & ~rail_en) <= 1));

    // R8
    pg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pg_mode |=> ((rail_en & ~$past(rail_en) & ~$past({pg_ok, 1'b1})) == '0));

endmodule

bind rail_sequencer seq_chk #(.N_RAILS(N_RAILS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .por_done (por_done),
    .seq_down (seq_down),
    .pg_mode  (pg_mode),
    .pg_ok    (pg_ok),
    .rail_en  (rail_en)
);

// File: tb/sim_rail_sequencer.sv
module sim_rail_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_done = 1'b0;
    logic        enable = 1'b0;
    logic        seq_down = 1'b0;
    logic        pg_mode = 1'b0;
    logic [2:0]  pg_good = 3'b000;
    logic [31:0] up_cfg = '0;
    logic [31:0] dn_cfg = '0;
    logic [3:0]  rail_en;

    int n_chk = 0;
    int n_fail = 0;

    int du[4];
    int dd[4];
    bit m_on[4];
    int m_h[4];
    logic [2:0] m_pg1 = '0;
    logic [2:0] m_pg2 = '0;

    always #10 clk = ~clk;

    rail_sequencer u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .por_done   (por_done),
        .enable     (enable),
        .seq_down   (seq_down),
        .pg_mode    (pg_mode),
        .pg_good    (pg_good),
        .up_dly_cfg (up_cfg),
        .dn_dly_cfg (dn_cfg),
        .rail_en    (rail_en)
    );

    function automatic void load_cfg();
        for (int i = 0; i < 4; i++) begin
            up_cfg[i*8 +: 8] = du[i][7:0];
            dn_cfg[i*8 +: 8] = dd[i][7:0];
        end
    endfunction

    function automatic logic [3:0] model_vec();
        logic [3:0] v;
        for (int i = 0; i < 4; i++) v[i] = m_on[i];
        return v;
    endfunction

    function automatic void model_clear();
        for (int i = 0; i < 4; i++) begin
            m_on[i] = 1'b0;
            m_h[i] = 0;
        end
        m_pg1 = '0;
        m_pg2 = '0;
    endfunction

    // Reference behaviour: hold counts in consecutive sampled edges
    function automatic void model_step();
        bit n_on[4];
        int n_h[4];
        bit enq = enable && por_done;
        for (int i = 0; i < 4; i++) begin
            n_on[i] = m_on[i];
            n_h[i] = 0;
            if (m_on[i]) begin
                bit nxt_off = (i == 3) ? 1'b1 : !m_on[i+1];
                if (!enq && !seq_down) begin
                    n_on[i] = 1'b0;
                end else if (!enq && nxt_off) begin
                    n_h[i] = m_h[i] + 1;
                    if (n_h[i] == dd[i] + 2) begin
                        n_on[i] = 1'b0;
                        n_h[i] = 0;
                    end
                end
            end else begin
                bit gu = (i == 0) ? enq : (m_on[i-1] && (!pg_mode || m_pg2[i-1]));
                if (enq && gu) begin
                    n_h[i] = m_h[i] + 1;
                    if (n_h[i] == du[i] + 2) begin
                        n_on[i] = 1'b1;
                        n_h[i] = 0;
                    end
                end
            end
        end
        for (int i = 0; i < 4; i++) begin
            m_on[i] = n_on[i];
            m_h[i] = n_h[i];
        end
        m_pg2 = m_pg1;
        m_pg1 = pg_good;
    endfunction

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: rail_en=%b expected %b", tag, act, exp);
        end
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(tag, rail_en, model_vec());
    endtask

    task automatic run(int n, string tag);
        for (int k = 0; k < n; k++) step(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", rail_en, 4'b0000);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (160000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        du = '{3, 5, 0, 7};
        dd = '{2, 4, 1, 6};
        load_cfg();
        do_reset();
        run(3, "R1");
        check("R1", rail_en, 4'b0000);

        // R2: enable without por_done
        enable = 1'b1;
        run(20, "R2");
        check("R2", rail_en, 4'b0000);

        // R3/R4: power-up chain, rises at 5,12,14,23
        por_done = 1'b1;
        for (int k = 1; k <= 23; k++) begin
            step("R4");
            if (k == 4)  check("R3", rail_en, 4'b0000);
            if (k == 5)  check("R3", rail_en, 4'b0001);
            if (k == 22) check("R4", rail_en, 4'b0111);
            if (k == 23) check("R4", rail_en, 4'b1111);
        end

        // R5: instant off
        enable = 1'b0;
        step("R5");
        check("R5", rail_en, 4'b0000);

        // R6: staged reverse shutdown, falls at 8,11,17,21
        enable = 1'b1;
        run(23, "R4");
        seq_down = 1'b1;
        enable = 1'b0;
        for (int k = 1; k <= 21; k++) begin
            step("R6");
            if (k == 7)  check("R6", rail_en, 4'b1111);
            if (k == 8)  check("R6", rail_en, 4'b0111);
            if (k == 11) check("R6", rail_en, 4'b0011);
            if (k == 21) check("R6", rail_en, 4'b0000);
        end

        // R7: re-enable during shutdown
        enable = 1'b1;
        run(23, "R4");
        enable = 1'b0;
        run(12, "R7");
        check("R7", rail_en, 4'b0011);
        enable = 1'b1;
        for (int k = 1; k <= 11; k++) begin
            step("R7");
            check("R7", {2'b11, rail_en[1:0]}, 4'b1111);
            if (k == 10) check("R7", rail_en, 4'b0111);
            if (k == 11) check("R7", rail_en, 4'b1111);
        end

        // R10: abort during up delay reloads
        seq_down = 1'b0;
        enable = 1'b0;
        du = '{7, 1, 1, 1};
        load_cfg();
        do_reset();
        enable = 1'b1;
        run(5, "R10");
        enable = 1'b0;
        step("R10");
        enable = 1'b1;
        for (int k = 1; k <= 9; k++) begin
            step("R10");
            if (k == 8) check("R10", rail_en, 4'b0000);
            if (k == 9) check("R10", rail_en, 4'b0001);
        end

        // R8/R9: power-good gating
        enable = 1'b0;
        du = '{1, 6, 1, 1};
        load_cfg();
        pg_mode = 1'b1;
        pg_good = 3'b000;
        do_reset();
        enable = 1'b1;
        run(20, "R8");
        check("R8", rail_en, 4'b0001);
        pg_good[0] = 1'b1;
        run(5, "R9");
        pg_good[0] = 1'b0;
        run(20, "R9");
        check("R9", rail_en, 4'b0001);
        pg_good[0] = 1'b1;
        for (int k = 1; k <= 10; k++) begin
            step("R8");
            if (k == 9)  check("R8", rail_en, 4'b0001);
            if (k == 10) check("R8", rail_en, 4'b0011);
        end
        pg_good[0] = 1'b0;
        run(20, "R9");
        check("R9", rail_en, 4'b0011);

        // Random phases against the reference model
        for (int ph = 0; ph < 4; ph++) begin
            enable = 1'b0;
            for (int i = 0; i < 4; i++) begin
                du[i] = $urandom_range(0, 9);
                dd[i] = $urandom_range(0, 9);
            end
            load_cfg();
            pg_mode = ph[0];
            seq_down = ph[1];
            por_done = 1'b1;
            pg_good = 3'b111;
            do_reset();
            for (int c = 0; c < 1500; c++) begin
                if ($urandom_range(0, 39) == 0) enable = ~enable;
                if ($urandom_range(0, 199) == 0) por_done = ~por_done;
                if ($urandom_range(0, 99) == 0) seq_down = ~seq_down;
                if ($urandom_range(0, 14) == 0) pg_good[$urandom_range(0, 2)] ^= 1'b1;
                step("R11");
                check("R11", (rail_en >> 1) & ~rail_en, 4'b0000);
            end
        end

        summary();
        $finish;
    end

endmodule